// File: doc/BRIEF.md
# Serial Flash Command and Status Controller

This block is the command-side logic of a small serial NOR flash memory seen from an SPI bus in mode 0, with data sent MSB first. The block oversamples the serial clock, chip select, data-in and write-protect pins in its own system clock domain. It turns the bit stream into bytes while chip select is low and decodes instructions from those bytes. It keeps a status register with a busy flag, a write-enable latch, a three-bit protection level and a lock bit.

Programming and erasing are allowed only after the write-enable latch is set. They are refused when the target lies in the protected area. An accepted instruction takes effect on the rising edge of chip select. The storage is a behavioural byte array. Programming can only clear bits, and erasing returns bytes to FFh. After each accepted program, erase or status write, a busy timer stands in for the internal cycle. While that timer runs, only a status read is served.

With the default parameters the array is 1024 bytes. It is split into four 256-byte sectors, and a page is 256 bytes.

Top module: `sfc_top`

## Requirements
- R1: The status byte is laid out as bit0 busy (WIP), bit1 write-enable latch (WEL), bits 4:2 protection level BP, bit7 lock bit SRWD, and bits 6:5 read 0. After reset it reads 00h. Opcode 05h returns it on every following byte. miso is 0 while chip select is high.
- R2: Opcode 06h sets WEL and opcode 04h clears it, at the moment the opcode byte completes.
- R3: Opcode 02h takes three address bytes (the low address bits are used) and then data bytes. On an aligned chip-select rise, each addressed byte becomes old AND new, so bits only go from 1 to 0. This happens only if WEL was 1 and the target is unprotected.
- R4: Page-program data that runs past the end of the 256-byte page wraps to offset 0 of the same page. Other pages are left untouched.
- R5: Opcode D8h plus three address bytes sets every byte of the addressed sector to FFh. Opcode C7h sets the whole array to FFh, and only when BP is 0.
- R6: Opcode 03h plus three address bytes streams bytes from incrementing addresses. After the last address it wraps to address 0.
- R7: An accepted program, erase or status write holds WIP at 1 for BUSY_CYC clock cycles. WEL clears when that busy period ends.
- R8: While WIP is 1, every opcode except 05h is ignored, including 06h and 04h.
- R9: A program, erase or status write sent with WEL at 0 changes nothing. One refused by protection clears WEL without starting a busy period.
- R10: A program, erase or status write is discarded with all state unchanged, including WEL, in two cases: chip select rises in the middle of a byte, or it rises before the address or data bytes the opcode needs have arrived.
- R11: BP 0 protects nothing. BP 1 protects the highest sector, BP 2 the two highest sectors, and BP 3 to 7 the whole array.
- R12: Opcode 01h with one data byte loads BP from data bits 4:2 and SRWD from data bit 7. It is refused (see R9) while SRWD is 1 and wp_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0, well below clk/8 |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data out of the block |

## Verification
Two things can land in the same clock cycle: the end of the busy period, which clears WEL, and the completion of a write-enable opcode, which sets WEL. The bench provokes this by sending write-enable commands back to back across the end of a sector erase. A completion that coincides with the end of busy must be ignored, and the checker requires that WEL never rises in the cycle after WIP was 1. Once WIP reads 0, one more write-enable must give a status of exactly 02h.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_BULK = 8'hC7;
  localparam logic [7:0] OP_SECT = 8'hD8;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_SKIP} sfc_st_e;
endpackage

// File: rtl/sfc_spi_rx.sv
module sfc_spi_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       cs_act,
  output logic       cs_rise,
  output logic       aligned,
  output logic       byte_vld,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic [2:0] cs_sr, sck_sr;
  logic [1:0] mosi_sr;
  logic [2:0] bit_q, bit_nx;
  logic [6:0] sh_q, sh_nx;
  logic [7:0] tx_q, tx_nx;
  logic       sck_r, sck_f;

  assign cs_act  = !cs_sr[1];
  assign cs_rise = cs_sr[1] & !cs_sr[2];
  assign sck_r   = sck_sr[1] & !sck_sr[2];
  assign sck_f   = !sck_sr[1] & sck_sr[2];
  assign aligned = (bit_q == 3'd0);
  assign rx_byte = {sh_q, mosi_sr[1]};
  assign miso    = tx_q[7];

  always_comb begin
    bit_nx   = bit_q;
    sh_nx    = sh_q;
    tx_nx    = tx_q;
    byte_vld = 1'b0;
    if (!cs_act) begin
      bit_nx = 3'd0;
      tx_nx  = 8'h00;
    end else begin
      if (sck_r) begin
        sh_nx    = {sh_q[5:0], mosi_sr[1]};
        bit_nx   = bit_q + 3'd1;
        byte_vld = (bit_q == 3'd7);
      end
      if (sck_f) tx_nx = (bit_q == 3'd0) ? tx_byte : {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr   <= 3'b111;
      sck_sr  <= 3'b000;
      mosi_sr <= 2'b00;
      bit_q   <= 3'd0;
      sh_q    <= 7'd0;
      tx_q    <= 8'h00;
    end else begin
      cs_sr   <= {cs_sr[1:0], cs_n};
      sck_sr  <= {sck_sr[1:0], sck};
      mosi_sr <= {mosi_sr[0], mosi};
      bit_q   <= bit_nx;
      sh_q    <= sh_nx;
      tx_q    <= tx_nx;
    end
  end
endmodule

// File: rtl/sfc_busy.sv
module sfc_busy #(
  parameter int BUSY_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt_q, cnt_nx;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

  always_comb begin
    cnt_nx = cnt_q;
    if (start)     cnt_nx = CW'(BUSY_CYC);
    else if (busy) cnt_nx = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/sfc_prot.sv
module sfc_prot #(
  parameter int ADDR_W = 10,
  parameter int SECT_W = 8
) (
  input  logic [2:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  localparam int SECT_IW = ADDR_W - SECT_W;
  localparam logic [31:0] NSECT = 32'(1) << SECT_IW;
  logic [31:0] span, sect;

  always_comb begin
    sect = 32'(addr[ADDR_W-1:SECT_W]);
    span = (bp == 3'd0) ? 32'd0 : (32'(1) << (bp - 3'd1));
    prot = (bp != 3'd0) && ((span >= NSECT) || (sect >= NSECT - span));
  end
endmodule

// File: rtl/sfc_store.sv
module sfc_store #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 8,
  parameter int SECT_W = 8
) (
  input  logic              clk,
  input  logic              buf_clr,
  input  logic              buf_wr,
  input  logic [PAGE_W-1:0] buf_idx,
  input  logic [7:0]        buf_din,
  input  logic              prog_go,
  input  logic              erase_sec,
  input  logic              erase_all,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [7:0] buf_q [PAGE];
  logic [7:0] mem_w [DEPTH];

  always_ff @(posedge clk) begin
    if (buf_clr) begin
      for (int i = 0; i < PAGE; i++) buf_q[i] <= 8'hFF;
    end else if (buf_wr) begin
      buf_q[buf_idx] <= buf_din;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [ADDR_W-1:0] AG = ADDR_W'(g);
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (erase_all || (erase_sec && AG[ADDR_W-1:SECT_W] == sel_addr[ADDR_W-1:SECT_W]))
        byte_q <= 8'hFF;
      else if (prog_go && AG[ADDR_W-1:PAGE_W] == sel_addr[ADDR_W-1:PAGE_W])
        byte_q <= byte_q & buf_q[AG[PAGE_W-1:0]];
    end
    assign mem_w[g] = byte_q;
  end

  assign rd_data = mem_w[rd_addr];
endmodule

// File: rtl/sfc_top.sv
module sfc_top
  import sfc_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 8,
  parameter int SECT_W   = 8,
  parameter int BUSY_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);
  logic              cs_act, cs_rise, aligned, byte_vld;
  logic [7:0]        rx_byte, tx_byte, rd_data, status;
  logic              wip, done, start, prot;
  logic              buf_clr, buf_wr, prog_go, erase_sec, erase_all;
  logic [1:0]        wp_q;
  logic              wp_s;

  sfc_st_e           st_q, st_nx;
  logic [7:0]        op_q, op_nx;
  logic [1:0]        acnt_q, acnt_nx;
  logic [ADDR_W-1:0] addr_q, addr_nx, rd_q, rd_nx, new_addr;
  logic [PAGE_W-1:0] off_q, off_nx;
  logic              got_q, got_nx, wel_q, wel_nx, srwd_q, srwd_nx;
  logic [2:0]        bp_q, bp_nx;
  logic [3:0]        wd_q, wd_nx;

  sfc_spi_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .tx_byte(tx_byte), .cs_act(cs_act), .cs_rise(cs_rise), .aligned(aligned),
    .byte_vld(byte_vld), .rx_byte(rx_byte), .miso(miso)
  );

  sfc_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(wip), .done(done)
  );

  sfc_prot #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_prot (
    .bp(bp_q), .addr(addr_q), .prot(prot)
  );

  sfc_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W)) u_store (
    .clk(clk), .buf_clr(buf_clr), .buf_wr(buf_wr), .buf_idx(off_q),
    .buf_din(rx_byte), .prog_go(prog_go), .erase_sec(erase_sec),
    .erase_all(erase_all), .sel_addr(addr_q), .rd_addr(rd_q), .rd_data(rd_data)
  );

  assign wp_s     = wp_q[1];
  assign status   = {srwd_q, 2'b00, bp_q, wel_q, wip};
  assign new_addr = ADDR_W'({addr_q, rx_byte});
  assign tx_byte  = (op_q == OP_RDSR) ? status :
                    (op_q == OP_READ && st_q == ST_DATA) ? rd_data : 8'h00;

  always_comb begin
    st_nx = st_q;   op_nx = op_q;     acnt_nx = acnt_q; addr_nx = addr_q;
    rd_nx = rd_q;   off_nx = off_q;   got_nx = got_q;   wel_nx = wel_q;
    bp_nx = bp_q;   srwd_nx = srwd_q; wd_nx = wd_q;
    start = 1'b0;   buf_clr = 1'b0;   buf_wr = 1'b0;
    prog_go = 1'b0; erase_sec = 1'b0; erase_all = 1'b0;
    if (done) wel_nx = 1'b0;
    if (cs_rise) begin
      st_nx  = ST_IDLE;
      got_nx = 1'b0;
      if (aligned && got_q) begin
        unique case (op_q)
          OP_PROG: if (wel_q && !prot) begin prog_go = 1'b1; start = 1'b1; end
                   else wel_nx = 1'b0;
          OP_SECT: if (wel_q && !prot) begin erase_sec = 1'b1; start = 1'b1; end
                   else wel_nx = 1'b0;
          OP_BULK: if (wel_q && bp_q == 3'd0) begin erase_all = 1'b1; start = 1'b1; end
                   else wel_nx = 1'b0;
          OP_WRSR: if (wel_q && !(srwd_q && !wp_s)) begin
                     srwd_nx = wd_q[3]; bp_nx = wd_q[2:0]; start = 1'b1;
                   end else wel_nx = 1'b0;
          default: ;
        endcase
      end
    end else if (byte_vld) begin
      unique case (st_q)
        ST_IDLE: begin
          op_nx   = rx_byte;
          acnt_nx = 2'd0;
          got_nx  = 1'b0;
          st_nx   = ST_SKIP;
          if (!wip || rx_byte == OP_RDSR) begin
            unique case (rx_byte)
              OP_WREN: wel_nx = 1'b1;
              OP_WRDI: wel_nx = 1'b0;
              OP_RDSR, OP_WRSR:         st_nx = ST_DATA;
              OP_BULK:                  got_nx = 1'b1;
              OP_PROG, OP_SECT, OP_READ: st_nx = ST_ADDR;
              default: ;
            endcase
          end
        end
        ST_ADDR: begin
          addr_nx = new_addr;
          acnt_nx = acnt_q + 2'd1;
          if (acnt_q == 2'd2) begin
            st_nx   = (op_q == OP_SECT) ? ST_SKIP : ST_DATA;
            got_nx  = (op_q != OP_READ);
            rd_nx   = new_addr;
            off_nx  = new_addr[PAGE_W-1:0];
            buf_clr = (op_q == OP_PROG);
          end
        end
        ST_DATA: begin
          if (op_q == OP_PROG) begin
            buf_wr = 1'b1;
            off_nx = off_q + PAGE_W'(1);
          end else if (op_q == OP_WRSR) begin
            wd_nx  = {rx_byte[7], rx_byte[4:2]};
            got_nx = 1'b1;
            st_nx  = ST_SKIP;
          end else if (op_q == OP_READ) begin
            rd_nx = rd_q + ADDR_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; op_q <= 8'h00; acnt_q <= 2'd0; addr_q <= '0;
      rd_q <= '0; off_q <= '0; got_q <= 1'b0; wel_q <= 1'b0;
      bp_q <= 3'd0; srwd_q <= 1'b0; wd_q <= 4'd0; wp_q <= 2'b11;
    end else begin
      st_q <= st_nx; op_q <= op_nx; acnt_q <= acnt_nx; addr_q <= addr_nx;
      rd_q <= rd_nx; off_q <= off_nx; got_q <= got_nx; wel_q <= wel_nx;
      bp_q <= bp_nx; srwd_q <= srwd_nx; wd_q <= wd_nx; wp_q <= {wp_q[0], wp_n};
    end
  end
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wip,
  input logic       wel,
  input logic [2:0] bp,
  input logic       srwd,
  input logic       wp_s,
  input logic       cs_act,
  input logic       miso
);
  // R7: the latch is already clear when the busy flag drops
  p_wel_clear_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  // R8: no write-enable takes effect while busy
  p_no_wel_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> !$rose(wel));

  // R9: a busy period is only entered with the latch set
  p_busy_needs_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));

  // R12: lock bit plus low write-protect freezes the protection fields
  p_hw_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (srwd && !wp_s) |=> $stable({srwd, bp}));

  // R1: output stays low while deselected
  p_quiet_miso_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act)) |-> !miso);
endmodule

bind sfc_top sfc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wip(wip), .wel(wel_q), .bp(bp_q),
  .srwd(srwd_q), .wp_s(wp_s), .cs_act(cs_act), .miso(miso)
);

// File: tb/sfc_top_tb_top.sv
module sfc_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic wp_n = 1'b1;
  logic miso;
  int checks = 0;
  int fails = 0;
  logic done_flag = 1'b0;

  always #10 clk = ~clk;

  sfc_top #(.BUSY_CYC(600)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .miso(miso)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (8) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic cs_on();
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_on(); xfer(op, d); cs_off();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_on(); xfer(8'h05, d); xfer(8'h00, s); cs_off();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 60; i++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic addr_cmd(input logic [7:0] op, input logic [9:0] a);
    logic [7:0] d;
    xfer(op, d); xfer(8'h00, d); xfer({6'd0, a[9:8]}, d); xfer(a[7:0], d);
  endtask

  task automatic prog(input logic [9:0] a, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input int n);
    logic [7:0] d;
    cs_on(); addr_cmd(8'h02, a);
    if (n > 0) xfer(b0, d);
    if (n > 1) xfer(b1, d);
    if (n > 2) xfer(b2, d);
    cs_off();
  endtask

  task automatic sect(input logic [9:0] a);
    cs_on(); addr_cmd(8'hD8, a); cs_off();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_on(); xfer(8'h01, d); xfer(v, d); cs_off();
  endtask

  task automatic read2(input logic [9:0] a, output logic [7:0] r0, output logic [7:0] r1);
    cs_on(); addr_cmd(8'h03, a); xfer(8'h00, r0); xfer(8'h00, r1); cs_off();
  endtask

  task automatic read1(input logic [9:0] a, output logic [7:0] r0);
    logic [7:0] r1;
    read2(a, r0, r1);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 miso low when deselected", {7'd0, miso}, 8'h00);
    rdsr(s); chk("R1 status after reset", s, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s;
    cmd1(8'h06); rdsr(s); chk("R2 write enable sets latch", s, 8'h02);
    cmd1(8'h04); rdsr(s); chk("R2 write disable clears latch", s, 8'h00);
  endtask

  task automatic t_bulk();
    logic [7:0] s, r0, r1;
    cmd1(8'hC7); rdsr(s); chk("R9 bulk erase without latch ignored", s, 8'h00);
    cmd1(8'h06); cmd1(8'hC7); rdsr(s); chk("R7 busy and latch during erase", s, 8'h03);
    cmd1(8'h06); rdsr(s); chk("R8 write enable ignored while busy", s, 8'h03);
    wait_idle(); rdsr(s); chk("R7 latch cleared at end of busy", s, 8'h00);
    read2(10'h000, r0, r1); chk("R5 bulk erase byte 0", r0, 8'hFF);
    read1(10'h3FF, r0); chk("R5 bulk erase last byte", r0, 8'hFF);
  endtask

  task automatic t_prog();
    logic [7:0] s, r0, r1;
    cmd1(8'h06); prog(10'h010, 8'hA5, 8'h3C, 8'h00, 2); wait_idle();
    read2(10'h010, r0, r1);
    chk("R3 program first byte", r0, 8'hA5);
    chk("R3 program second byte", r1, 8'h3C);
    read1(10'h012, r0); chk("R3 byte past data untouched", r0, 8'hFF);
    cmd1(8'h06); prog(10'h010, 8'h0F, 8'hFF, 8'h00, 2); wait_idle();
    read2(10'h010, r0, r1);
    chk("R3 bits only cleared", r0, 8'h05);
    chk("R3 ones do not set bits", r1, 8'h3C);
    rdsr(s); chk("R7 latch clear after program", s, 8'h00);
  endtask

  task automatic t_wrap();
    logic [7:0] r0, r1;
    cmd1(8'h06); prog(10'h0FE, 8'h11, 8'h22, 8'h33, 3); wait_idle();
    read2(10'h0FE, r0, r1);
    chk("R4 offset FE", r0, 8'h11);
    chk("R4 offset FF", r1, 8'h22);
    read1(10'h000, r0); chk("R4 wrapped to page start", r0, 8'h33);
    read1(10'h100, r0); chk("R4 next page untouched", r0, 8'hFF);
    read2(10'h3FF, r0, r1);
    chk("R6 read last address", r0, 8'hFF);
    chk("R6 read wraps to address 0", r1, 8'h33);
  endtask

  task automatic t_nowel();
    logic [7:0] s, r0, d;
    prog(10'h020, 8'h00, 8'h00, 8'h00, 1); rdsr(s);
    chk("R9 program without latch not started", s, 8'h00);
    read1(10'h020, r0); chk("R9 program without latch no change", r0, 8'hFF);
    cmd1(8'h06);
    cs_on(); addr_cmd(8'h02, 10'h030); xbits(8'h00, 4, d); cs_off();
    rdsr(s); chk("R10 partial byte discarded, latch kept", s, 8'h02);
    read1(10'h030, r0); chk("R10 partial byte no change", r0, 8'hFF);
    cs_on(); xfer(8'hD8, d); xfer(8'h00, d); cs_off();
    rdsr(s); chk("R10 short address discarded", s, 8'h02);
    cmd1(8'h04);
  endtask

  task automatic t_bp();
    logic [7:0] s, r0;
    cmd1(8'h06); wrsr(8'h04); wait_idle(); rdsr(s); chk("R12 BP written", s, 8'h04);
    cmd1(8'h06); prog(10'h310, 8'h00, 8'h00, 8'h00, 1); rdsr(s);
    chk("R11 top sector refused, latch cleared", s, 8'h04);
    read1(10'h310, r0); chk("R11 protected byte unchanged", r0, 8'hFF);
    cmd1(8'h06); prog(10'h2F0, 8'h00, 8'h00, 8'h00, 1); wait_idle();
    read1(10'h2F0, r0); chk("R11 lower sector programmable", r0, 8'h00);
    cmd1(8'h06); cmd1(8'hC7); rdsr(s); chk("R5 bulk erase blocked by BP", s, 8'h04);
    cmd1(8'h06); sect(10'h300); rdsr(s); chk("R11 sector erase refused", s, 8'h04);
    cmd1(8'h06); wrsr(8'h08); wait_idle();
    cmd1(8'h06); sect(10'h200); rdsr(s); chk("R11 BP2 covers third sector", s, 8'h08);
    read1(10'h2F0, r0); chk("R11 third sector kept", r0, 8'h00);
  endtask

  task automatic t_hw();
    logic [7:0] s;
    cmd1(8'h06); wrsr(8'h84); wait_idle(); rdsr(s); chk("R12 lock bit written", s, 8'h84);
    wp_n = 1'b0;
    cmd1(8'h06); wrsr(8'h00); rdsr(s); chk("R12 locked status write refused", s, 8'h84);
    wp_n = 1'b1;
    cmd1(8'h06); wrsr(8'h00); wait_idle(); rdsr(s); chk("R12 unlocked status write", s, 8'h00);
  endtask

  task automatic t_sect();
    logic [7:0] r0;
    cmd1(8'h06); prog(10'h100, 8'h5A, 8'h00, 8'h00, 1); wait_idle();
    cmd1(8'h06); sect(10'h0AB); wait_idle();
    read1(10'h010, r0); chk("R5 sector erased", r0, 8'hFF);
    read1(10'h100, r0); chk("R5 other sector kept", r0, 8'h5A);
  endtask

  task automatic t_race();
    logic [7:0] s, r0;
    cmd1(8'h06); sect(10'h200);
    for (int i = 0; i < 60; i++) begin
      cmd1(8'h06);
      rdsr(s);
      if (!s[0]) break;
    end
    cmd1(8'h06); rdsr(s); chk("R8 write enable after busy ends", s, 8'h02);
    read1(10'h2F0, r0); chk("R5 erase done under write-enable stream", r0, 8'hFF);
    cmd1(8'h04);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_latch();
    t_bulk();
    t_prog();
    t_wrap();
    t_nowel();
    t_bp();
    t_hw();
    t_sect();
    t_race();
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule